// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Serial Bus

This block is an I2C target that holds a small bank of 8-bit configuration registers. It serves two kinds of transfer, both of which carry an explicit byte count. In a block write, the controller sends a starting index, a byte count and then that many data bytes. Those bytes fill consecutive registers. In a block read, the controller first sets the index in a short write phase. It then issues a repeated start with the read address. The target answers with a count byte, taken from a programmable count register, and follows it with register bytes until the controller refuses a byte.

SCL and SDA are oversampled by the system clock. The target drives the bus only through an open-drain enable: a 1 pulls SDA low. The whole register file is presented in parallel on one output vector so that neighbouring logic can use the settings directly. Reset values are set per register by a parameter. Two identification registers hold fixed values.

Top module: `i2c_blkreg_target`

## Requirements
- R1: The target acknowledges an address byte of 0xD2 (write) or 0xD3 (read) by pulling SDA low during the ninth SCL pulse. Any other address byte gets no acknowledge, and SDA stays released until the next start.
- R2: A write transfer consists of 0xD2, an index N, a count X and X data bytes. The target acknowledges every byte and stores data byte k into register N+k.
- R3: Once X data bytes have arrived, any further data byte gets no acknowledge and changes no register.
- R4: The index advances after every data byte. A write to an index at or beyond NUM_REGS is acknowledged and discarded. A read from such an index returns 0x00.
- R5: After a repeated start with 0xD3, the target first sends the count register value. It then sends the registers from the current index upward, MSB first.
- R6: The count register sits at index 8, resets to 0x0F and is writable. Its current value is the count byte sent in every read.
- R7: Index 6 reads as {REV_ID, VENDOR_ID} (vendor nibble 0x1 in bits 3:0) and index 7 reads as DEVICE_ID. Writes to either register are acknowledged but have no effect.
- R8: A not-acknowledge from the controller ends the read. SDA is released from the next SCL low phase onward and stays released through the stop.
- R9: After reset, SDA is released and every other register holds its byte of RESET_VALS (register i in bits 8i+7:8i).
- R10: SCL and SDA pass through a two-flop synchronizer. Start and stop are taken as SDA edges while SCL is high. The target changes SDA only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| regs_o | output | NUM_REGS*8 | All registers, register i in bits 8i+7:8i |

## Verification
A bus edge reaches the control logic three clock cycles after it appears on the pins: two synchronizer flops and one edge register. So an acknowledge or a transmitted bit shows on SDA about three cycles after SCL falls. The bench holds each SCL quarter-phase for ten cycles and samples SDA in the middle of the SCL high phase. That is at least twenty cycles after any change the target makes. Register updates take effect on the SCL fall that starts the acknowledge slot, and the bench compares the whole register vector only after the stop. A monitor flags any change of the SDA enable while the bench holds SCL high.

// File: rtl/i2c_blkreg_pkg.sv
package i2c_blkreg_pkg;

    // 7-bit target address; the write byte is 0xD2 and the read byte 0xD3
    localparam logic [6:0] TARGET_ADDR7 = 7'h69;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_HOLD
    } link_state_e;

    typedef enum logic [1:0] {
        RX_ADDR,
        RX_INDEX,
        RX_COUNT,
        RX_DATA
    } rx_kind_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } bus_evt_t;

    typedef struct packed {
        logic       en;
        logic [7:0] idx;
        logic [7:0] data;
    } reg_wr_t;

    function automatic logic addr_hit(input logic [7:0] b);
        return b[7:1] == TARGET_ADDR7;
    endfunction

    function automatic logic [7:0] idx_step(input logic [7:0] i);
        return (i == 8'hFF) ? i : i + 8'd1;
    endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync
    import i2c_blkreg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_comb begin
        evt_o.scl      = scl_s;
        evt_o.sda      = sda_s;
        evt_o.start    = scl_s & scl_d & sda_d & ~sda_s;
        evt_o.stop     = scl_s & scl_d & ~sda_d & sda_s;
        evt_o.scl_rise = scl_s & ~scl_d;
        evt_o.scl_fall = ~scl_s & scl_d;
    end

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_blkreg_pkg::*;
#(
    parameter int                    NUM_REGS    = 16,
    parameter int                    COUNT_IDX   = 8,
    parameter int                    ID_LO_IDX   = 6,
    parameter int                    ID_HI_IDX   = 7,
    parameter logic [7:0]            COUNT_RESET = 8'h0F,
    parameter logic [7:0]            ID_LO_VAL   = 8'h01,
    parameter logic [7:0]            ID_HI_VAL   = 8'h00,
    parameter logic [NUM_REGS*8-1:0] RESET_VALS  = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  reg_wr_t               wr_i,
    input  logic [7:0]            rd_idx_i,
    output logic [7:0]            rd_data_o,
    output logic [7:0]            count_o,
    output logic [NUM_REGS*8-1:0] regs_o
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == ID_LO_IDX) begin : g_id_lo
            assign regs_o[i*8 +: 8] = ID_LO_VAL;
        end else if (i == ID_HI_IDX) begin : g_id_hi
            assign regs_o[i*8 +: 8] = ID_HI_VAL;
        end else begin : g_rw
            localparam logic [7:0] RV = (i == COUNT_IDX) ? COUNT_RESET
                                                         : RESET_VALS[i*8 +: 8];
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= RV;
                end else if (wr_i.en && wr_i.idx == 8'(i)) begin
                    q <= wr_i.data;
                end
            end
            assign regs_o[i*8 +: 8] = q;
        end
    end

    always_comb begin
        rd_data_o = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx_i == 8'(i)) begin
                rd_data_o = regs_o[i*8 +: 8];
            end
        end
    end

    assign count_o = regs_o[COUNT_IDX*8 +: 8];

endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
    import i2c_blkreg_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt_i,
    input  logic [7:0] rd_data_i,
    input  logic [7:0] count_i,
    output logic [7:0] rd_idx_o,
    output reg_wr_t    wr_o,
    output logic       sda_oe_o
);

    link_state_e state;
    rx_kind_e    kind;
    logic [7:0]  shreg;
    logic [2:0]  bitcnt;
    logic        byte_done;
    logic        is_read;
    logic [7:0]  idx;
    logic [7:0]  remain;
    logic        ctrl_nack;

    assign rd_idx_o = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            kind      <= RX_ADDR;
            shreg     <= '0;
            bitcnt    <= '0;
            byte_done <= 1'b0;
            is_read   <= 1'b0;
            idx       <= '0;
            remain    <= '0;
            ctrl_nack <= 1'b0;
            sda_oe_o  <= 1'b0;
            wr_o      <= '0;
        end else begin
            wr_o.en <= 1'b0;
            if (evt_i.start) begin
                state     <= ST_RX;
                kind      <= RX_ADDR;
                bitcnt    <= '0;
                byte_done <= 1'b0;
                sda_oe_o  <= 1'b0;
            end else if (evt_i.stop) begin
                state     <= ST_IDLE;
                byte_done <= 1'b0;
                sda_oe_o  <= 1'b0;
            end else begin
                unique case (state)
                    ST_RX: begin
                        if (evt_i.scl_rise) begin
                            shreg  <= {shreg[6:0], evt_i.sda};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) byte_done <= 1'b1;
                        end else if (evt_i.scl_fall && byte_done) begin
                            byte_done <= 1'b0;
                            unique case (kind)
                                RX_ADDR: begin
                                    if (addr_hit(shreg)) begin
                                        is_read  <= shreg[0];
                                        kind     <= RX_INDEX;
                                        sda_oe_o <= 1'b1;
                                        state    <= ST_ACK;
                                    end else begin
                                        state <= ST_HOLD;
                                    end
                                end
                                RX_INDEX: begin
                                    idx      <= shreg;
                                    kind     <= RX_COUNT;
                                    sda_oe_o <= 1'b1;
                                    state    <= ST_ACK;
                                end
                                RX_COUNT: begin
                                    remain   <= shreg;
                                    kind     <= RX_DATA;
                                    sda_oe_o <= 1'b1;
                                    state    <= ST_ACK;
                                end
                                RX_DATA: begin
                                    if (remain != 8'd0) begin
                                        remain    <= remain - 8'd1;
                                        wr_o.en   <= (int'(idx) < NUM_REGS);
                                        wr_o.idx  <= idx;
                                        wr_o.data <= shreg;
                                        idx       <= idx_step(idx);
                                        sda_oe_o  <= 1'b1;
                                        state     <= ST_ACK;
                                    end else begin
                                        state <= ST_HOLD;
                                    end
                                end
                                default: state <= ST_HOLD;
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (evt_i.scl_fall) begin
                            bitcnt <= '0;
                            if (is_read) begin
                                shreg    <= count_i;
                                sda_oe_o <= ~count_i[7];
                                state    <= ST_TX;
                            end else begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (evt_i.scl_rise) begin
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) byte_done <= 1'b1;
                        end else if (evt_i.scl_fall) begin
                            if (byte_done) begin
                                byte_done <= 1'b0;
                                sda_oe_o  <= 1'b0;
                                state     <= ST_TX_ACK;
                            end else begin
                                shreg    <= {shreg[6:0], 1'b0};
                                sda_oe_o <= ~shreg[6];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (evt_i.scl_rise) begin
                            ctrl_nack <= evt_i.sda;
                        end else if (evt_i.scl_fall) begin
                            bitcnt <= '0;
                            if (ctrl_nack) begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_HOLD;
                            end else begin
                                shreg    <= rd_data_i;
                                sda_oe_o <= ~rd_data_i[7];
                                idx      <= idx_step(idx);
                                state    <= ST_TX;
                            end
                        end
                    end
                    default: begin
                        sda_oe_o <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_blkreg_target.sv
module i2c_blkreg_target
    import i2c_blkreg_pkg::*;
#(
    parameter int                    NUM_REGS    = 16,
    parameter int                    COUNT_IDX   = 8,
    parameter int                    ID_LO_IDX   = 6,
    parameter int                    ID_HI_IDX   = 7,
    parameter logic [7:0]            COUNT_RESET = 8'h0F,
    parameter logic [3:0]            VENDOR_ID   = 4'h1,
    parameter logic [3:0]            REV_ID      = 4'h2,
    parameter logic [7:0]            DEVICE_ID   = 8'h5A,
    parameter logic [NUM_REGS*8-1:0] RESET_VALS  = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] regs_o
);

    localparam logic [7:0] ID_LO_VAL = {REV_ID, VENDOR_ID};

    bus_evt_t   bus_evt;
    reg_wr_t    reg_wr;
    logic [7:0] rd_idx;
    logic [7:0] rd_data;
    logic [7:0] count_val;

    i2c_bus_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (bus_evt)
    );

    i2c_link_fsm #(.NUM_REGS(NUM_REGS)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (bus_evt),
        .rd_data_i (rd_data),
        .count_i   (count_val),
        .rd_idx_o  (rd_idx),
        .wr_o      (reg_wr),
        .sda_oe_o  (sda_oe_o)
    );

    i2c_reg_bank #(
        .NUM_REGS    (NUM_REGS),
        .COUNT_IDX   (COUNT_IDX),
        .ID_LO_IDX   (ID_LO_IDX),
        .ID_HI_IDX   (ID_HI_IDX),
        .COUNT_RESET (COUNT_RESET),
        .ID_LO_VAL   (ID_LO_VAL),
        .ID_HI_VAL   (DEVICE_ID),
        .RESET_VALS  (RESET_VALS)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (reg_wr),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data),
        .count_o   (count_val),
        .regs_o    (regs_o)
    );

endmodule

// File: rtl/i2c_blkreg_checker.sv
module i2c_blkreg_checker #(
    parameter int NUM_REGS  = 16,
    parameter int ID_LO_IDX = 6,
    parameter int ID_HI_IDX = 7
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  scl_s,
    input logic                  bus_start,
    input logic                  bus_stop,
    input logic                  sda_oe,
    input logic                  wr_en,
    input logic [7:0]            wr_idx,
    input logic [NUM_REGS*8-1:0] regs
);

    // R10: the data enable moves only while synchronized SCL is low
    a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    // R1: a start or stop leaves SDA released
    a_r1_release_on_bus_cond: assert property (@(posedge clk) disable iff (rst)
        (bus_start || bus_stop) |=> !sda_oe);

    // R4: the bank never receives a write strobe for a missing register
    a_r4_write_in_range: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < NUM_REGS));

    // R7: identification bytes survive writes aimed at them
    a_r7_id_lo_held: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_idx) == ID_LO_IDX) |=> $stable(regs[ID_LO_IDX*8 +: 8]));

    a_r7_id_hi_held: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_idx) == ID_HI_IDX) |=> $stable(regs[ID_HI_IDX*8 +: 8]));

    // R9: SDA is released right after reset
    a_r9_released_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !sda_oe);

endmodule

bind i2c_blkreg_target i2c_blkreg_checker #(
    .NUM_REGS  (NUM_REGS),
    .ID_LO_IDX (ID_LO_IDX),
    .ID_HI_IDX (ID_HI_IDX)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (bus_evt.scl),
    .bus_start (bus_evt.start),
    .bus_stop  (bus_evt.stop),
    .sda_oe    (sda_oe_o),
    .wr_en     (reg_wr.en),
    .wr_idx    (reg_wr.idx),
    .regs      (regs_o)
);

// File: tb/i2c_blkreg_target_bench.sv
`timescale 1ns/1ps
module i2c_blkreg_target_bench;

    localparam int NREG = 16;
    localparam int Q    = 10;
    localparam logic [NREG*8-1:0] RV = 128'hAFAEADACABAAA9A8A7A6A5A4A3A2A1A0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] regs;
    wire  sda_line = sda_drv & ~sda_oe;

    int errors = 0;
    int checks = 0;
    int r10_viol = 0;
    logic oe_seen = 1'b0;
    logic prev_oe = 1'b0;
    logic done = 1'b0;
    logic [7:0] model [NREG];

    always #2.5 clk = ~clk;

    i2c_blkreg_target #(.RESET_VALS(RV)) u_i2c_blkreg_target (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_drv),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .regs_o   (regs)
    );

    always @(posedge clk) begin
        if (sda_oe) oe_seen <= 1'b1;
        if (!rst && sda_oe != prev_oe && scl_drv) r10_viol <= r10_viol + 1;
        prev_oe <= sda_oe;
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_drv = 1'b1; tick(Q);
        scl_drv = 1'b1; tick(Q);
        sda_drv = 1'b0; tick(Q);
        scl_drv = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_drv = 1'b0; tick(Q);
        scl_drv = 1'b1; tick(Q);
        sda_drv = 1'b1; tick(2*Q);
    endtask

    task automatic put_bit(input logic b);
        sda_drv = b; tick(Q);
        scl_drv = 1'b1; tick(2*Q);
        scl_drv = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_drv = 1'b1; tick(Q);
        scl_drv = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_drv = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        acked = ~a;
    endtask

    task automatic get_byte(input logic nack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(nack);
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < NREG; i++) chk(tag, regs[i*8 +: 8], model[i]);
    endtask

    task automatic block_write(input string tag, input logic [7:0] idx,
                               input logic [7:0] cnt, input logic [7:0] d0,
                               input logic [7:0] d1, input logic [7:0] d2,
                               input int nbytes);
        logic a;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        bus_start;
        put_byte(8'hD2, a); chk({tag, " R1 addr ack"}, 8'(a), 8'd1);
        put_byte(idx, a);   chk({tag, " R2 index ack"}, 8'(a), 8'd1);
        put_byte(cnt, a);   chk({tag, " R2 count ack"}, 8'(a), 8'd1);
        for (int k = 0; k < nbytes; k++) begin
            put_byte(d[k], a);
            chk({tag, " data ack"}, 8'(a), (k < int'(cnt)) ? 8'd1 : 8'd0);
        end
        bus_stop;
    endtask

    task automatic read_setup(input logic [7:0] idx);
        logic a;
        bus_start;
        put_byte(8'hD2, a); chk("R5 setup addr ack", 8'(a), 8'd1);
        put_byte(idx, a);   chk("R5 setup index ack", 8'(a), 8'd1);
        bus_start;
        put_byte(8'hD3, a); chk("R1 read addr ack", 8'(a), 8'd1);
    endtask

    task automatic t_reset;
        tick(3);
        chk("R9 sda released", 8'(sda_oe), 8'd0);
        chk("R6 count reset", regs[8*8 +: 8], 8'h0F);
        chk("R7 id lo", regs[6*8 +: 8], 8'h21);
        chk("R7 id hi", regs[7*8 +: 8], 8'h5A);
        check_regs("R9 reset values");
    endtask

    task automatic t_block_write;
        block_write("R2 write", 8'd2, 8'd3, 8'h11, 8'h22, 8'h33, 3);
        model[2] = 8'h11; model[3] = 8'h22; model[4] = 8'h33;
        check_regs("R2 regs after write");
    endtask

    task automatic t_block_read;
        logic [7:0] v;
        read_setup(8'd2);
        get_byte(1'b0, v); chk("R5 R6 count byte", v, 8'h0F);
        get_byte(1'b0, v); chk("R5 byte 2", v, 8'h11);
        get_byte(1'b0, v); chk("R5 byte 3", v, 8'h22);
        get_byte(1'b1, v); chk("R5 byte 4", v, 8'h33);
        tick(Q);
        oe_seen = 1'b0;
        tick(2*Q);
        chk("R8 released after nack", 8'(oe_seen), 8'd0);
        bus_stop;
        chk("R8 released through stop", 8'(oe_seen), 8'd0);
    endtask

    task automatic t_bad_addr;
        logic a;
        bus_start;
        oe_seen = 1'b0;
        put_byte(8'hA0, a);
        chk("R1 foreign address nack", 8'(a), 8'd0);
        put_byte(8'h00, a);
        chk("R1 no drive after foreign address", 8'(oe_seen), 8'd0);
        bus_stop;
        check_regs("R1 regs untouched");
    endtask

    task automatic t_ro_write;
        block_write("R7 write id", 8'd6, 8'd2, 8'hFF, 8'hFF, 8'h00, 2);
        check_regs("R7 id unchanged");
    endtask

    task automatic t_over_count;
        block_write("R3 over count", 8'd0, 8'd1, 8'h44, 8'h55, 8'h00, 2);
        model[0] = 8'h44;
        check_regs("R3 extra byte dropped");
    endtask

    task automatic t_past_end;
        logic [7:0] v;
        block_write("R4 past end", 8'd15, 8'd3, 8'h66, 8'h77, 8'h88, 3);
        model[15] = 8'h66;
        check_regs("R4 regs after past-end write");
        read_setup(8'd15);
        get_byte(1'b0, v); chk("R4 count byte", v, 8'h0F);
        get_byte(1'b0, v); chk("R4 last reg", v, 8'h66);
        get_byte(1'b1, v); chk("R4 beyond end reads zero", v, 8'h00);
        bus_stop;
    endtask

    task automatic t_count_prog;
        logic [7:0] v;
        block_write("R6 program count", 8'd8, 8'd1, 8'h05, 8'h00, 8'h00, 1);
        model[8] = 8'h05;
        check_regs("R6 regs after count write");
        read_setup(8'd0);
        get_byte(1'b0, v); chk("R6 programmed count byte", v, 8'h05);
        get_byte(1'b1, v); chk("R5 reg 0 after count", v, 8'h44);
        bus_stop;
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = RV[i*8 +: 8];
        model[6] = 8'h21;
        model[7] = 8'h5A;
        model[8] = 8'h0F;
        tick(5);
        rst = 1'b0;
        t_reset;
        t_block_write;
        t_block_read;
        t_bad_addr;
        t_ro_write;
        t_over_count;
        t_past_end;
        t_count_prog;
        chk("R10 SDA changes only with SCL low", 8'(r10_viol), 8'd0);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule